// File: doc/BRIEF.md
# Line-Tagged Multiplexed Receive Silo

This block gathers received characters from sixteen serial lines into one shared queue. Each line's receiver presents a finished character as a one-cycle strobe, with a parity-error flag and a framing-error flag. The block holds one waiting character per line, moves the lowest-numbered waiting character into a 64-entry queue each cycle, and tags every queued word with its source line and its error conditions.

The host sees the head of the queue as a 16-bit receive word whose top bit says whether the word is valid. It pops one entry per read strobe, so it can drain the queue by reading until the top bit comes back clear. A control word carries the receive and storage interrupt enables, their flags and a master clear. A separate alarm level sets the fill count at which the storage interrupt fires.

Top module: `rx_silo_mux`

## Requirements
- R1: `rcv_data[15]` is 1 exactly when the queue holds at least one entry. With the queue empty, `rcv_data` is all zero.
- R2: A valid receive word packs the character in bits 7:0, the source line number in bits 11:8, the parity-error flag in bit 12, the framing-error flag in bit 13 and the overrun flag in bit 14.
- R3: A strobe on a line is captured at that clock edge. On each edge the lowest-numbered line that holds a waiting character moves it into the queue, so at most one entry enters per cycle. A character enters the queue no sooner than two edges after its strobe.
- R4: A strobe on a line whose previous character is still waiting, and is not moved on that same edge, replaces that character. The replacement carries the overrun flag.
- R5: A character moved on while the queue holds 64 entries is discarded. The next entry accepted afterwards carries the overrun flag.
- R6: Each cycle with `rcv_rd` high and a non-empty queue removes exactly one entry. With the queue empty, `rcv_rd` has no effect.
- R7: Control bit 6 is the read/write receive interrupt enable. Control bit 7 reads 1 while the queue is non-empty. `irq_rx` is high when both are 1.
- R8: Control bit 12 is the read/write storage interrupt enable. Control bit 14 reads 1 while the fill count is greater than or equal to the alarm level. `irq_store` is high when both are 1.
- R9: The alarm level resets to 16, is written through `alarm_wr`/`alarm_wdata` with values from 0 to 64, and reads back on `alarm_level`.
- R10: A control write with bit 11 set empties the queue, discards every waiting character, clears the pending overrun and both enables, and keeps the alarm level. Bit 11 reads as 0, and so do all control bits other than 6, 7, 12 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_stb | input | 16 | Per-line character-ready strobe |
| rx_char | input | 128 | Per-line character, line n in bits 8n+7:8n |
| rx_perr | input | 16 | Per-line parity-error flag, qualified by strobe |
| rx_ferr | input | 16 | Per-line framing-error flag, qualified by strobe |
| rcv_rd | input | 1 | Pop strobe for the receive word |
| rcv_data | output | 16 | Head-of-queue receive word |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write data |
| csr_rdata | output | 16 | Control word read value |
| alarm_wr | input | 1 | Alarm level write strobe |
| alarm_wdata | input | 7 | Alarm level write data |
| alarm_level | output | 7 | Current alarm level |
| irq_rx | output | 1 | Receive interrupt |
| irq_store | output | 1 | Storage interrupt |

## Verification
The assertions assume that the alarm level is never written above the queue depth and that a master clear takes effect on the same edge as the control write that carries it. They make no assumption about how many lines strobe together. The stimulus writes alarm values only in the range 0 to 64. After reset it holds every input idle until the internal reset has been released. It strobes freely across all lines, including lines that already hold a waiting character and lines that strobe while the queue is full, and it pops at random rates, including pops on an empty queue.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CHAR_W   = 8;
  localparam int LINE_W   = 4;
  localparam int NLINES   = 1 << LINE_W;
  localparam int ENTRY_W  = CHAR_W + LINE_W + 3;
  localparam int WORD_W   = ENTRY_W + 1;

  localparam int BIT_RIE  = 6;
  localparam int BIT_RI   = 7;
  localparam int BIT_MCLR = 11;
  localparam int BIT_SIE  = 12;
  localparam int BIT_SI   = 14;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rxs_entry_t;
endpackage

// File: rtl/rxs_rst_sync.sv
module rxs_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/rxs_capture.sv
module rxs_capture
  import rxs_pkg::*;
#(
  parameter int NL = NLINES,
  parameter int CW = CHAR_W,
  parameter int LW = LINE_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic [NL-1:0]    stb,
  input  logic [NL*CW-1:0] chr_in,
  input  logic [NL-1:0]    perr_in,
  input  logic [NL-1:0]    ferr_in,
  input  logic             full,
  output logic             push_valid,
  output rxs_entry_t       push_entry
);
  logic [NL-1:0] pend_q, pend_d;
  logic [NL-1:0] ovr_q, ovr_d;
  logic [NL-1:0] perr_q, perr_d;
  logic [NL-1:0] ferr_q, ferr_d;
  logic [CW-1:0] chr_q [NL];
  logic [CW-1:0] chr_d [NL];
  logic          drop_q, drop_d;
  logic [NL-1:0] grant;
  logic [LW-1:0] gidx;
  logic          found;

  // Fixed priority: lowest line number wins
  always_comb begin
    grant = '0;
    gidx  = '0;
    found = 1'b0;
    for (int i = 0; i < NL; i++) begin
      if (pend_q[i] && !found) begin
        grant[i] = 1'b1;
        gidx     = LW'(i);
        found    = 1'b1;
      end
    end
  end

  assign push_valid = found;

  always_comb begin
    push_entry.ovr  = ovr_q[gidx] | drop_q;
    push_entry.ferr = ferr_q[gidx];
    push_entry.perr = perr_q[gidx];
    push_entry.line = gidx;
    push_entry.ch   = chr_q[gidx];
  end

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      pend_d[i] = pend_q[i];
      ovr_d[i]  = ovr_q[i];
      perr_d[i] = perr_q[i];
      ferr_d[i] = ferr_q[i];
      chr_d[i]  = chr_q[i];
      if (clr) begin
        pend_d[i] = 1'b0;
        ovr_d[i]  = 1'b0;
      end else if (stb[i]) begin
        pend_d[i] = 1'b1;
        ovr_d[i]  = pend_q[i] & ~grant[i];
        perr_d[i] = perr_in[i];
        ferr_d[i] = ferr_in[i];
        chr_d[i]  = chr_in[i*CW +: CW];
      end else if (grant[i]) begin
        pend_d[i] = 1'b0;
      end
    end
  end

  always_comb begin
    if (clr)             drop_d = 1'b0;
    else if (push_valid) drop_d = full;
    else                 drop_d = drop_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovr_q  <= '0;
      perr_q <= '0;
      ferr_q <= '0;
      drop_q <= 1'b0;
      for (int i = 0; i < NL; i++) chr_q[i] <= '0;
    end else begin
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      drop_q <= drop_d;
      for (int i = 0; i < NL; i++) chr_q[i] <= chr_d[i];
    end
  end

  AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_valid && full && !clr) |=> drop_q); // R5
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 15,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr,
  input  logic             push_req,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  output logic             full,
  output logic [CNT_W-1:0] count,
  output logic [W-1:0]     head
);
  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             do_push, do_pop;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign do_push = push_req & ~full & ~clr;
  assign do_pop  = pop_req & (count_q != '0) & ~clr;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_d = (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_d = count_q + 1'b1;
        2'b01:   count_d = count_q - 1'b1;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // Storage array: written only under its enable, no reset needed
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH)); // R5
  AST_POP_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (pop_req && count_q == '0 && !push_req) |=> count_q == '0); // R6
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int ALARM_RST = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              csr_wr,
  input  logic [WORD_W-1:0] csr_wdata,
  input  logic              alarm_wr,
  input  logic [CNT_W-1:0]  alarm_wdata,
  input  logic [CNT_W-1:0]  count,
  output logic              clr,
  output logic [WORD_W-1:0] csr_rdata,
  output logic [CNT_W-1:0]  alarm_level,
  output logic              irq_rx,
  output logic              irq_store
);
  logic             rie_q, rie_d;
  logic             sie_q, sie_d;
  logic [CNT_W-1:0] alarm_q, alarm_d;
  logic             ri, si;
  logic             unused_wbits;

  assign unused_wbits = ^{csr_wdata[WORD_W-1:BIT_SIE+1], csr_wdata[BIT_SIE-1:BIT_MCLR+1],
                          csr_wdata[BIT_MCLR-1:BIT_RIE+1], csr_wdata[BIT_RIE-1:0]};

  assign clr = csr_wr & csr_wdata[BIT_MCLR];

  always_comb begin
    rie_d   = rie_q;
    sie_d   = sie_q;
    alarm_d = alarm_q;
    if (clr) begin
      rie_d = 1'b0;
      sie_d = 1'b0;
    end else if (csr_wr) begin
      rie_d = csr_wdata[BIT_RIE];
      sie_d = csr_wdata[BIT_SIE];
    end
    if (alarm_wr) alarm_d = alarm_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rie_q   <= 1'b0;
      sie_q   <= 1'b0;
      alarm_q <= CNT_W'(ALARM_RST);
    end else begin
      rie_q   <= rie_d;
      sie_q   <= sie_d;
      alarm_q <= alarm_d;
    end
  end

  assign ri = (count != '0);
  assign si = (count >= alarm_q);

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[BIT_RIE] = rie_q;
    csr_rdata[BIT_RI]  = ri;
    csr_rdata[BIT_SIE] = sie_q;
    csr_rdata[BIT_SI]  = si;
  end

  assign alarm_level = alarm_q;
  assign irq_rx      = rie_q & ri;
  assign irq_store   = sie_q & si;

  AST_IRQ_RX_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_rx |-> count != '0); // R7
endmodule

// File: rtl/rx_silo_mux.sv
module rx_silo_mux
  import rxs_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int ALARM_RST = 16,
  localparam int CNT_W    = $clog2(DEPTH) + 1
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic [NLINES-1:0]      rx_stb,
  input  logic [NLINES*CHAR_W-1:0] rx_char,
  input  logic [NLINES-1:0]      rx_perr,
  input  logic [NLINES-1:0]      rx_ferr,
  input  logic                   rcv_rd,
  output logic [WORD_W-1:0]      rcv_data,
  input  logic                   csr_wr,
  input  logic [WORD_W-1:0]      csr_wdata,
  output logic [WORD_W-1:0]      csr_rdata,
  input  logic                   alarm_wr,
  input  logic [CNT_W-1:0]       alarm_wdata,
  output logic [CNT_W-1:0]       alarm_level,
  output logic                   irq_rx,
  output logic                   irq_store
);
  logic             rst_n;
  logic             clr;
  logic             full;
  logic             push_valid;
  rxs_entry_t       push_entry;
  logic [CNT_W-1:0] count;
  logic [ENTRY_W-1:0] head;

  rxs_rst_sync u_rst (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  rxs_capture #(.NL(NLINES), .CW(CHAR_W), .LW(LINE_W)) u_cap (
    .clk        (clk),
    .rst_ni     (rst_n),
    .clr        (clr),
    .stb        (rx_stb),
    .chr_in     (rx_char),
    .perr_in    (rx_perr),
    .ferr_in    (rx_ferr),
    .full       (full),
    .push_valid (push_valid),
    .push_entry (push_entry)
  );

  rxs_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk       (clk),
    .rst_ni    (rst_n),
    .clr       (clr),
    .push_req  (push_valid),
    .push_data (push_entry),
    .pop_req   (rcv_rd),
    .full      (full),
    .count     (count),
    .head      (head)
  );

  rxs_ctrl #(.CNT_W(CNT_W), .ALARM_RST(ALARM_RST)) u_ctrl (
    .clk         (clk),
    .rst_ni      (rst_n),
    .csr_wr      (csr_wr),
    .csr_wdata   (csr_wdata),
    .alarm_wr    (alarm_wr),
    .alarm_wdata (alarm_wdata),
    .count       (count),
    .clr         (clr),
    .csr_rdata   (csr_rdata),
    .alarm_level (alarm_level),
    .irq_rx      (irq_rx),
    .irq_store   (irq_store)
  );

  assign rcv_data = (count != '0) ? {1'b1, head} : '0;

  AST_VALID_MATCHES_RI: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_data[WORD_W-1] == csr_rdata[BIT_RI]); // R1
  AST_MCLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rcv_data == '0 && !irq_rx && !irq_store)); // R10
endmodule

// File: tb/rx_silo_mux_bench.sv
module rx_silo_mux_bench;
  localparam int CLK_P = 10;
  localparam int NL    = 16;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] rx_stb = '0;
  logic [NL*8-1:0] rx_char = '0;
  logic [NL-1:0] rx_perr = '0;
  logic [NL-1:0] rx_ferr = '0;
  logic          rcv_rd = 1'b0;
  logic [15:0]   rcv_data;
  logic          csr_wr = 1'b0;
  logic [15:0]   csr_wdata = '0;
  logic [15:0]   csr_rdata;
  logic          alarm_wr = 1'b0;
  logic [6:0]    alarm_wdata = '0;
  logic [6:0]    alarm_level;
  logic          irq_rx, irq_store;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rx_silo_mux u_rx_silo_mux (
    .clk(clk), .rst_ni(rst_n), .rx_stb(rx_stb), .rx_char(rx_char),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rcv_rd(rcv_rd), .rcv_data(rcv_data),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .alarm_wr(alarm_wr), .alarm_wdata(alarm_wdata), .alarm_level(alarm_level),
    .irq_rx(irq_rx), .irq_store(irq_store)
  );

  // Behavioural reference model
  logic [14:0] mq[$];
  bit  m_pend[NL];
  bit  m_ovr[NL];
  bit  m_pe[NL];
  bit  m_fe[NL];
  logic [7:0] m_ch[NL];
  bit  m_drop;
  bit  m_rie, m_sie;
  int  m_alarm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      for (int i = 0; i < NL; i++) begin m_pend[i] = 0; m_ovr[i] = 0; end
      m_drop = 0; m_rie = 0; m_sie = 0; m_alarm = 16;
    end else begin
      if (csr_wr && csr_wdata[11]) begin
        mq.delete();
        for (int i = 0; i < NL; i++) begin m_pend[i] = 0; m_ovr[i] = 0; end
        m_drop = 0; m_rie = 0; m_sie = 0;
      end else begin
        int g;
        bit was_full, do_pop;
        g = -1;
        for (int i = 0; i < NL; i++) if (m_pend[i] && g < 0) g = i;
        was_full = (mq.size() == DEPTH);
        do_pop = rcv_rd && (mq.size() > 0);
        if (do_pop) void'(mq.pop_front());
        if (g >= 0) begin
          if (!was_full) begin
            mq.push_back({m_ovr[g] | m_drop, m_fe[g], m_pe[g], 4'(g), m_ch[g]});
            m_drop = 0;
          end else m_drop = 1;
        end
        for (int i = 0; i < NL; i++) begin
          if (rx_stb[i]) begin
            m_ovr[i]  = m_pend[i] && (g != i);
            m_pend[i] = 1;
            m_ch[i]   = rx_char[i*8 +: 8];
            m_pe[i]   = rx_perr[i];
            m_fe[i]   = rx_ferr[i];
          end else if (g == i) m_pend[i] = 0;
        end
        if (csr_wr) begin m_rie = csr_wdata[6]; m_sie = csr_wdata[12]; end
      end
      if (alarm_wr) m_alarm = int'(alarm_wdata);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [15:0] e_data, e_csr;
      bit e_ri, e_si;
      e_ri   = mq.size() > 0;
      e_si   = mq.size() >= m_alarm;
      e_data = e_ri ? {1'b1, mq[0]} : 16'h0;
      e_csr  = '0;
      e_csr[6] = m_rie; e_csr[7] = e_ri; e_csr[12] = m_sie; e_csr[14] = e_si;
      chk("R1 R2 receive word", rcv_data, e_data);
      chk("R7 R8 control word", csr_rdata, e_csr);
      chk("R7 irq_rx", irq_rx, m_rie & e_ri);
      chk("R8 irq_store", irq_store, m_sie & e_si);
      chk("R9 alarm level", alarm_level, m_alarm);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    rx_stb = '0; rx_perr = '0; rx_ferr = '0;
    rcv_rd = 0; csr_wr = 0; alarm_wr = 0;
  endtask

  task automatic strobe(int line, logic [7:0] c, bit pe, bit fe);
    rx_stb[line] = 1'b1;
    rx_char[line*8 +: 8] = c;
    rx_perr[line] = pe;
    rx_ferr[line] = fe;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_errs++; n_checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    #(CLK_P * 3 + 1);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step();

    // Reset state
    chk("R1 reset word", rcv_data, 16'h0000);
    chk("R7 reset control", csr_rdata, 16'h0000);
    chk("R9 reset alarm", alarm_level, 16);

    // Priority across simultaneous lines, field packing
    strobe(3, 8'h33, 1, 0); strobe(1, 8'h11, 0, 1); step();
    step(); step();
    chk("R3 lowest line first", rcv_data, 16'hA111);
    rcv_rd = 1; step();
    chk("R2 parity bit 12 line 3", rcv_data, 16'h9333);
    rcv_rd = 1; step();
    chk("R6 pop to empty", rcv_data, 16'h0000);
    rcv_rd = 1; step();
    chk("R6 pop on empty ignored", rcv_data, 16'h0000);
    chk("R6 ri clear", csr_rdata[7], 1'b0);

    // Overwrite of a waiting character
    strobe(0, 8'hA0, 0, 0); strobe(5, 8'h55, 0, 0); step();
    strobe(5, 8'h56, 0, 0); step();
    step();
    chk("R4 first entry", rcv_data, 16'h80A0);
    rcv_rd = 1; step();
    chk("R4 replaced with overrun", rcv_data, 16'hC556);
    rcv_rd = 1; step();

    // Enables and alarm
    csr_wr = 1; csr_wdata = 16'h1040; step();
    chk("R7 R8 enables read back", csr_rdata, 16'h1040);
    strobe(1, 8'h01, 0, 0); step(); step();
    chk("R7 irq_rx with data", irq_rx, 1'b1);
    chk("R8 below alarm", irq_store, 1'b0);
    alarm_wr = 1; alarm_wdata = 7'd1; step();
    chk("R8 at alarm", irq_store, 1'b1);
    chk("R8 control flags", csr_rdata, 16'h50C0);
    alarm_wr = 1; alarm_wdata = 7'd0; step();
    chk("R9 alarm zero", alarm_level, 0);
    rcv_rd = 1; step();
    chk("R8 level zero still asserts", irq_store, 1'b1);
    alarm_wr = 1; alarm_wdata = 7'd16; step();

    // Fill past full
    for (int k = 0; k < DEPTH; k++) begin strobe(2, 8'(k), 0, 0); step(); end
    step();
    chk("R5 full raises storage flag", csr_rdata[14], 1'b1);
    strobe(2, 8'hEE, 0, 0); step();
    strobe(2, 8'hEF, 0, 0); step(); step();
    chk("R5 head kept when full", rcv_data, 16'h8200);
    rcv_rd = 1; step();
    strobe(2, 8'h77, 0, 0); step(); step();
    for (int k = 1; k < DEPTH; k++) begin
      chk("R5 R6 drain order", rcv_data, 16'h8200 | 16'(k));
      rcv_rd = 1; step();
    end
    chk("R5 overrun after drop", rcv_data, 16'hC277);
    rcv_rd = 1; step();
    chk("R6 drained", rcv_data, 16'h0000);

    // Master clear
    csr_wr = 1; csr_wdata = 16'h1040; step();
    strobe(4, 8'h44, 0, 0); step(); step();
    strobe(9, 8'h99, 0, 0); step();
    csr_wr = 1; csr_wdata = 16'h1840; step();
    chk("R10 queue emptied", rcv_data, 16'h0000);
    chk("R10 control cleared", csr_rdata, 16'h0000);
    step(); step();
    chk("R10 waiting char dropped", rcv_data, 16'h0000);
    chk("R10 alarm kept", alarm_level, 16);
    strobe(6, 8'h66, 0, 0); step(); step();
    chk("R10 normal after clear", rcv_data, 16'h8666);
    rcv_rd = 1; step();

    // Random traffic
    for (int c = 0; c < 5000; c++) begin
      for (int i = 0; i < NL; i++)
        if ($urandom_range(0, 9) == 0)
          strobe(i, 8'($urandom), 1'($urandom), 1'($urandom));
      rcv_rd = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 49) == 0) begin
        alarm_wr = 1; alarm_wdata = 7'($urandom_range(0, DEPTH));
      end
      if ($urandom_range(0, 99) == 0) begin
        csr_wr = 1;
        csr_wdata = 16'($urandom) & 16'h1040;
        if ($urandom_range(0, 9) == 0) csr_wdata[11] = 1'b1;
      end
      step();
    end
    step(); step();
    finish_run();
  end
endmodule